// File: doc/BRIEF.md
# Sensor ADC Command Register Front End

This block sits between a simple 32-bit word-addressed register bus and the control side of an on-chip sensor converter. Software drives it by writing command words to a command port. Each word either reads or writes one of the converter's internal 16-bit registers, or does nothing. Here those registers are plain storage. Results return through a data FIFO with a lag of one command. Each accepted command first pushes the result of the command before it, then holds its own result until the next command arrives. A read returns the addressed register, while a write or a no-op returns zero.

Around the command path sit a configuration word, a status word that reports the data FIFO level, an interrupt status register with write-one-to-clear bits, an interrupt mask and a control word. The control word has a hold bit that locks out commands. The block drives one level-sensitive interrupt line. A command completes in the cycle it is written, so the command side never has a backlog.

Top module: `adc_cmd_regif`

## Requirements
- R1: After reset, configuration reads 0x00001814, interrupt status reads 0x00000200, the mask reads 0xFFFFFFFF, control reads 0x00000010, status reads 0x00000500, the interrupt line is low and the result FIFO is empty.
- R2: The byte offsets are: configuration 0x00, interrupt status 0x04, mask 0x08, status 0x0C (read-only), command port 0x10 (write-only), result FIFO 0x14 (read-only), control 0x18. A read of 0x10 or of an unmapped offset returns 0. A write to 0x0C, 0x14 or an unmapped offset changes nothing.
- R3: A command word has the opcode in bits 29:26, the register address in bits 25:16 and the data in bits 15:0. An accepted read (opcode 1) pushes the pending result into the FIFO, then makes the addressed register's contents the new pending result.
- R4: An accepted write (opcode 2) stores bits 15:0 into the addressed register, pushes the pending result and sets the pending result to 0. A no-op (opcode 0) pushes the pending result and sets it to 0.
- R5: When the FIFO holds its full depth, the push of an accepted command is dropped, but the pending result is still replaced.
- R6: While control bit 4 is set, commands are ignored. Control writes are ANDed with 0x00FFFEFF.
- R7: A read or write whose register address is at or above the bank size is ignored entirely. A no-op is accepted with any address. Opcodes 3 to 15 are ignored.
- R8: A read of 0x14 returns the oldest entry and removes it. On an empty FIFO it returns 0 and leaves the level unchanged.
- R9: Interrupt status is write-one-to-clear. Bit 9 is set again in every cycle. Bit 8 is set one cycle after the FIFO level exceeds configuration bits 19:16, and it cannot be cleared while the level still exceeds them.
- R10: A mask write keeps only bits 9:0 and clears the rest. The interrupt line is high when any status bit is set whose mask bit is clear.
- R11: A status read shows bit 10 always set, the FIFO level in bits 15:12, bit 8 when the level is 0, and bit 9 when the level equals the depth.
- R12: Configuration is fully readable and writable across all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 15-entry result FIFO and a 128-register bank. At these sizes the FIFO level fills the 4-bit status field exactly, so the full flag, the dropped push and the pending value that survives the drop can all be reached with a few dozen commands. The 128-entry bank leaves the register-address field several bits wider than the bank. That puts out-of-range addresses such as 200 within reach, together with no-ops at address 0x3FF.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

   // word indices on the register bus (byte offset / 4)
   localparam int IDX_CFG  = 0;
   localparam int IDX_ISTS = 1;
   localparam int IDX_IMSK = 2;
   localparam int IDX_STAT = 3;
   localparam int IDX_CMD  = 4;
   localparam int IDX_RES  = 5;
   localparam int IDX_CTRL = 6;

   localparam logic [31:0] CFG_RST    = 32'h0000_1814;
   localparam logic [31:0] CTRL_RST   = 32'h0000_0010;
   localparam logic [31:0] CTRL_WMASK = 32'h00FF_FEFF;
   localparam int          CTRL_HOLD  = 4;

   // interrupt status layout
   localparam int STS_W         = 10;
   localparam int STS_CMD_LOW   = 9;
   localparam int STS_RES_ABOVE = 8;

   // command word fields
   localparam int CMD_OP_LSB   = 26;
   localparam int CMD_OP_W     = 4;
   localparam int CMD_ADDR_LSB = 16;
   localparam int CMD_ADDR_W   = 10;
   localparam int CMD_DATA_W   = 16;

   typedef enum logic [CMD_OP_W-1:0] {
      OP_NOP   = 4'd0,
      OP_READ  = 4'd1,
      OP_WRITE = 4'd2
   } adc_op_e;

   // status word layout
   localparam int STAT_LVL_LSB   = 12;
   localparam int STAT_LVL_W     = 4;
   localparam int STAT_CMD_EMPTY = 10;
   localparam int STAT_RES_FULL  = 9;
   localparam int STAT_RES_EMPTY = 8;

endpackage

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
   parameter int DEPTH = 15,
   parameter int W     = 16,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [W-1:0]     push_data_i,
   input  logic             pop_i,
   output logic [W-1:0]     head_o,
   output logic [LVL_W-1:0] level_o,
   output logic             full_o,
   output logic             empty_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("adc_result_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [LVL_W-1:0] lvl_q;
   logic             do_push, do_pop;

   assign full_o  = (lvl_q == LVL_W'(DEPTH));
   assign empty_o = (lvl_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign level_o = lvl_q;
   assign head_o  = empty_o ? '0 : mem_q[rd_q];

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (do_push) begin
            mem_q[wr_q] <= push_data_i;
            wr_q        <= step(wr_q);
         end
         if (do_pop) rd_q <= step(rd_q);
         lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
      end
   end

   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && full_o) |=> (level_o == LVL_W'(DEPTH))); // R5

   AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && empty_o) |=> empty_o); // R8

endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank #(
   parameter int NREGS     = 128,
   parameter int AW        = 10,
   parameter int DW        = 16,
   parameter bit RESET_MEM = 1'b1,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);

   if (NREGS > (1 << AW) || NREGS < 2) begin : g_bad_size
      $error("adc_reg_bank: NREGS must lie in 2 .. 2**AW");
   end

   logic [DW-1:0] regs_q [NREGS];
   logic          in_range;

   assign in_range = (32'(addr_i) < NREGS);
   assign rdata_o  = in_range ? regs_q[addr_i[IDX_W-1:0]] : '0;

   if (RESET_MEM) begin : g_reset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
         end else if (we_i && in_range) begin
            regs_q[addr_i[IDX_W-1:0]] <= wdata_i;
         end
      end
   end else begin : g_noreset
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (we_i && in_range) regs_q[addr_i[IDX_W-1:0]] <= wdata_i;
      end
   end

endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit #(
   parameter int STS_W   = 10,
   parameter int LVL_W   = 4,
   parameter int THR_W   = 4,
   parameter int CMD_BIT = 9,
   parameter int RES_BIT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_we_i,
   input  logic [31:0]      clr_bits_i,
   input  logic             mask_we_i,
   input  logic [STS_W-1:0] mask_bits_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [THR_W-1:0] thresh_i,
   output logic [31:0]      sts_o,
   output logic [31:0]      mask_o,
   output logic             irq_o
);

   if (STS_W > 32 || CMD_BIT >= STS_W || RES_BIT >= STS_W) begin : g_bad_layout
      $error("adc_irq_unit: status bit positions out of range");
   end

   logic [STS_W-1:0] sts_q, mask_q, set_v, clr_v;
   logic             mask_hi_q;
   logic             above;

   assign above = (32'(level_i) > 32'(thresh_i));

   always_comb begin
      set_v          = '0;
      set_v[CMD_BIT] = 1'b1;
      set_v[RES_BIT] = above;
      clr_v          = clr_we_i ? clr_bits_i[STS_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q          <= '0;
         sts_q[CMD_BIT] <= 1'b1;
         mask_q         <= '1;
         mask_hi_q      <= 1'b1;
      end else begin
         sts_q <= (sts_q & ~clr_v) | set_v;
         if (mask_we_i) begin
            mask_q    <= mask_bits_i;
            mask_hi_q <= 1'b0;
         end
      end
   end

   assign sts_o  = 32'(sts_q);
   assign mask_o = {{(32 - STS_W){mask_hi_q}}, mask_q};
   assign irq_o  = |(sts_q & ~mask_q);

   AST_ABOVE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      above |=> sts_o[RES_BIT]); // R9

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_bits_i[RES_BIT] && !above) |=> !sts_o[RES_BIT]); // R9

   AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (mask_o[31:STS_W] == '0)); // R10

endmodule

// File: rtl/adc_cmd_regif.sv
module adc_cmd_regif #(
   parameter int FIFO_DEPTH = 15,
   parameter int BANK_REGS  = 128,
   parameter int ADDR_W     = 8,
   parameter bit BANK_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o
);
   import adc_regif_pkg::*;

   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
   localparam int WI_W  = ADDR_W - 2;

   if (LVL_W > STAT_LVL_W) begin : g_bad_fifo
      $error("adc_cmd_regif: FIFO level must fit the 4-bit status field");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("adc_cmd_regif: ADDR_W too small for the register map");
   end

   logic [WI_W-1:0] widx;
   logic            aligned;
   logic            sel_cfg, sel_ists, sel_imsk, sel_stat, sel_cmd, sel_res, sel_ctrl;

   assign widx     = bus_addr_i[ADDR_W-1:2];
   assign aligned  = (bus_addr_i[1:0] == 2'b00);
   assign sel_cfg  = aligned && widx == WI_W'(IDX_CFG);
   assign sel_ists = aligned && widx == WI_W'(IDX_ISTS);
   assign sel_imsk = aligned && widx == WI_W'(IDX_IMSK);
   assign sel_stat = aligned && widx == WI_W'(IDX_STAT);
   assign sel_cmd  = aligned && widx == WI_W'(IDX_CMD);
   assign sel_res  = aligned && widx == WI_W'(IDX_RES);
   assign sel_ctrl = aligned && widx == WI_W'(IDX_CTRL);

   // command decode
   logic [CMD_OP_W-1:0]   cmd_op;
   logic [CMD_ADDR_W-1:0] cmd_addr;
   logic [CMD_DATA_W-1:0] cmd_data;
   logic                  cmd_hit, op_known, addr_ok, cmd_accept;

   assign cmd_op     = bus_wdata_i[CMD_OP_LSB +: CMD_OP_W];
   assign cmd_addr   = bus_wdata_i[CMD_ADDR_LSB +: CMD_ADDR_W];
   assign cmd_data   = bus_wdata_i[CMD_DATA_W-1:0];
   assign cmd_hit    = bus_wr_i && sel_cmd;
   assign op_known   = (cmd_op == OP_NOP) || (cmd_op == OP_READ) || (cmd_op == OP_WRITE);
   assign addr_ok    = (32'(cmd_addr) < BANK_REGS);
   assign cmd_accept = cmd_hit && !ctrl_q[CTRL_HOLD] && op_known
                       && ((cmd_op == OP_NOP) || addr_ok);

   logic [31:0]           cfg_q, ctrl_q;
   logic [CMD_DATA_W-1:0] pending_q, bank_rdata, fifo_head;
   logic [LVL_W-1:0]      fifo_lvl;
   logic                  fifo_full, fifo_empty, res_pop;
   logic [31:0]           ists, imsk;

   assign res_pop = bus_rd_i && sel_res;

   adc_reg_bank #(
      .NREGS     (BANK_REGS),
      .AW        (CMD_ADDR_W),
      .DW        (CMD_DATA_W),
      .RESET_MEM (BANK_RESET)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cmd_accept && cmd_op == OP_WRITE),
      .addr_i  (cmd_addr),
      .wdata_i (cmd_data),
      .rdata_o (bank_rdata)
   );

   adc_result_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (CMD_DATA_W)
   ) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (cmd_accept),
      .push_data_i (pending_q),
      .pop_i       (res_pop),
      .head_o      (fifo_head),
      .level_o     (fifo_lvl),
      .full_o      (fifo_full),
      .empty_o     (fifo_empty)
   );

   adc_irq_unit #(
      .STS_W   (STS_W),
      .LVL_W   (LVL_W),
      .THR_W   (4),
      .CMD_BIT (STS_CMD_LOW),
      .RES_BIT (STS_RES_ABOVE)
   ) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_we_i    (bus_wr_i && sel_ists),
      .clr_bits_i  (bus_wdata_i),
      .mask_we_i   (bus_wr_i && sel_imsk),
      .mask_bits_i (bus_wdata_i[STS_W-1:0]),
      .level_i     (fifo_lvl),
      .thresh_i    (cfg_q[19:16]),
      .sts_o       (ists),
      .mask_o      (imsk),
      .irq_o       (irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= CFG_RST;
         ctrl_q    <= CTRL_RST;
         pending_q <= '0;
      end else begin
         if (bus_wr_i && sel_cfg)  cfg_q  <= bus_wdata_i;
         if (bus_wr_i && sel_ctrl) ctrl_q <= bus_wdata_i & CTRL_WMASK;
         if (cmd_accept) pending_q <= (cmd_op == OP_READ) ? bank_rdata : '0;
      end
   end

   logic [31:0] stat_word;
   always_comb begin
      stat_word                               = '0;
      stat_word[STAT_CMD_EMPTY]               = 1'b1;
      stat_word[STAT_LVL_LSB +: LVL_W]        = fifo_lvl;
      stat_word[STAT_RES_EMPTY]               = fifo_empty;
      stat_word[STAT_RES_FULL]                = fifo_full;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_rd_i) begin
         if (sel_cfg)       bus_rdata_o = cfg_q;
         else if (sel_ists) bus_rdata_o = ists;
         else if (sel_imsk) bus_rdata_o = imsk;
         else if (sel_stat) bus_rdata_o = stat_word;
         else if (sel_res)  bus_rdata_o = 32'(fifo_head);
         else if (sel_ctrl) bus_rdata_o = ctrl_q;
      end
   end

   AST_HOLD_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && ctrl_q[CTRL_HOLD] && !bus_rd_i) |=> $stable(fifo_lvl)); // R6

   AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && sel_ctrl) |=> ((ctrl_q & ~CTRL_WMASK) == '0)); // R6

   AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && cmd_op != OP_NOP && !addr_ok && !res_pop) |=> $stable(fifo_lvl)); // R7

   AST_RES_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && sel_stat) |=> $stable(cfg_q)); // R2

endmodule

// File: tb/adc_cmd_regif_bench.sv
module adc_cmd_regif_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 23;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_cmd_regif u_adc_cmd_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_rd_i    (rd),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   // {is_read, offset, write data, expected read, requirement number}
   localparam logic [80:0] VEC [NVEC] = '{
      {1'b0, 8'h18, 32'h0000_0000, 32'h0, 8'd6},        // R6 release hold
      {1'b1, 8'h18, 32'h0, 32'h0000_0000, 8'd6},
      {1'b0, 8'h00, 32'hA5A3_5A5A, 32'h0, 8'd12},       // R12
      {1'b1, 8'h00, 32'h0, 32'hA5A3_5A5A, 8'd12},
      {1'b0, 8'h10, 32'h0805_1234, 32'h0, 8'd4},        // R4 write reg 5
      {1'b0, 8'h10, 32'h0405_0000, 32'h0, 8'd3},        // R3 read reg 5
      {1'b0, 8'h10, 32'h03FF_0000, 32'h0, 8'd7},        // R7 nop addr 0x3FF
      {1'b1, 8'h0C, 32'h0, 32'h0000_3400, 8'd11},       // R11 level 3
      {1'b1, 8'h14, 32'h0, 32'h0000_0000, 8'd3},
      {1'b1, 8'h14, 32'h0, 32'h0000_0000, 8'd4},
      {1'b1, 8'h14, 32'h0, 32'h0000_1234, 8'd3},
      {1'b1, 8'h14, 32'h0, 32'h0000_0000, 8'd8},        // R8 empty pop
      {1'b1, 8'h0C, 32'h0, 32'h0000_0500, 8'd8},
      {1'b0, 8'h10, 32'h04C8_0000, 32'h0, 8'd7},        // read addr 200
      {1'b1, 8'h0C, 32'h0, 32'h0000_0500, 8'd7},
      {1'b0, 8'h10, 32'h0C01_0000, 32'h0, 8'd7},        // opcode 3
      {1'b1, 8'h0C, 32'h0, 32'h0000_0500, 8'd7},
      {1'b1, 8'h10, 32'h0, 32'h0000_0000, 8'd2},        // R2 write-only port
      {1'b1, 8'h1C, 32'h0, 32'h0000_0000, 8'd2},
      {1'b0, 8'h0C, 32'h0000_FFFF, 32'h0, 8'd2},
      {1'b1, 8'h0C, 32'h0, 32'h0000_0500, 8'd2},
      {1'b0, 8'h14, 32'h0000_DEAD, 32'h0, 8'd2},
      {1'b1, 8'h0C, 32'h0, 32'h0000_0500, 8'd2}
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(tag, d, exp);
   endtask

   task automatic irq_check(input string tag, input logic exp);
      #1 check(tag, 32'(irq), 32'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      irq_check("R1 irq", 1'b0);
      read_check("R1 cfg",  8'h00, 32'h0000_1814);
      read_check("R1 ists", 8'h04, 32'h0000_0200);
      read_check("R1 mask", 8'h08, 32'hFFFF_FFFF);
      read_check("R1 ctrl", 8'h18, 32'h0000_0010);
      read_check("R1 stat", 8'h0C, 32'h0000_0500);
      read_check("R1 pop",  8'h14, 32'h0000_0000);

      // R6 hold bit set at reset blocks commands
      bus_write(8'h10, 32'h0000_0000);
      read_check("R6 held nop", 8'h0C, 32'h0000_0500);

      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] d;
         if (VEC[i][80]) begin
            bus_read(VEC[i][79:72], d);
            checks++;
            if (d !== VEC[i][39:8]) begin
               errors++;
               $display("FAIL table step %0d R%0d: got %08h expected %08h",
                        i, VEC[i][7:0], d, VEC[i][39:8]);
            end
         end else begin
            bus_write(VEC[i][79:72], VEC[i][71:40]);
         end
      end

      // R9 threshold is cfg[19:16] = 3
      bus_write(8'h04, 32'h0000_0300);
      read_check("R9 after w1c", 8'h04, 32'h0000_0200);
      repeat (3) bus_write(8'h10, 32'h0000_0000);
      read_check("R9 level equal thr", 8'h04, 32'h0000_0200);
      bus_write(8'h10, 32'h0000_0000);
      read_check("R9 level above thr", 8'h04, 32'h0000_0300);
      irq_check("R10 masked", 1'b0);
      bus_write(8'h08, 32'hFFFF_FEFF);
      read_check("R10 mask bits", 8'h08, 32'h0000_02FF);
      irq_check("R10 unmasked bit8", 1'b1);
      bus_write(8'h04, 32'h0000_0100);
      read_check("R9 w1c while above", 8'h04, 32'h0000_0300);
      repeat (4) read_check("R8 drain", 8'h14, 32'h0000_0000);
      bus_write(8'h04, 32'h0000_0100);
      read_check("R9 w1c cleared", 8'h04, 32'h0000_0200);
      irq_check("R10 irq low", 1'b0);
      bus_write(8'h04, 32'h0000_0200);
      read_check("R9 bit9 returns", 8'h04, 32'h0000_0200);
      bus_write(8'h08, 32'h0000_01FF);
      irq_check("R10 bit9 unmasked", 1'b1);
      bus_write(8'h08, 32'h0000_03FF);
      irq_check("R10 all masked", 1'b0);

      // R5 full FIFO drops the push but keeps the pending value
      bus_write(8'h10, 32'h0807_BEEF);
      repeat (14) bus_write(8'h10, 32'h0000_0000);
      read_check("R11 full", 8'h0C, 32'h0000_F600);
      bus_write(8'h10, 32'h0407_0000);
      read_check("R5 level stays", 8'h0C, 32'h0000_F600);
      read_check("R5 head", 8'h14, 32'h0000_0000);
      bus_write(8'h10, 32'h0000_0000);
      repeat (14) read_check("R5 zeros", 8'h14, 32'h0000_0000);
      read_check("R5 kept pending", 8'h14, 32'h0000_BEEF);
      read_check("R11 empty", 8'h0C, 32'h0000_0500);

      // R6 control mask and hold
      bus_write(8'h18, 32'hFFFF_FFFF);
      read_check("R6 ctrl mask", 8'h18, 32'h00FF_FEFF);
      bus_write(8'h10, 32'h0000_0000);
      read_check("R6 held", 8'h0C, 32'h0000_0500);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule